// File: doc/BRIEF.md
# SD Card Block Read Receiver (single DAT line)

This host-side block takes in the read data that an SD card drives on one DAT line. One bit is sampled per clock. After the command path signals that a read command has finished, the receiver watches the idle-high line for a start bit. This wait is needed because the card's access delay varies. Once the start bit appears, the receiver shifts in a data block whose length is set in bytes. It then collects the sixteen check bits that follow the data, compares them with its own CRC16, and verifies the closing bit. Data bytes leave on a valid/ready byte stream. Each block ends with a one-cycle status report.

In single-block mode the receiver goes back to idle after one block. In multi-block mode it hunts for the next start bit after each block, and keeps doing so until the command path reports that a stop command has been sent. The card keeps driving for two clocks after that command's end bit. The receiver still uses those samples and then drops whatever block is only partly received. A programmable limit on the idle-high wait turns a silent card into a timeout report.

Top module: `sd_blk_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are cleared and the receiver is idle. After release, no output changes until `rd_start` is seen.
- R2: After `rd_start`, samples of 1 are skipped. The first 0 sample is the start bit. The following samples are data, most significant bit of each byte first.
- R3: Each byte appears on `out_data` with `out_valid` high in the cycle after its eighth bit is sampled. It is held unchanged until a cycle with `out_ready` high. The consumer must accept within eight cycles.
- R4: The receiver runs CRC16 (polynomial 0x1021, start value 0, MSB first) over the data bits only and compares it with the 16 bits that follow, sent MSB first. In the cycle after the closing-bit sample, `block_done` pulses together with `crc_ok` on a match, or with `crc_err` otherwise.
- R5: The sample after the check bits must be 1. A 0 there raises `framing_err` together with `block_done`.
- R6: If `timeout_lim` consecutive 1 samples arrive while waiting for a start bit, `rd_timeout` pulses in the next cycle and the receiver returns to idle without reporting a block.
- R7: A block holds `blk_len` bytes. A value of 0 selects `DEF_BLK_LEN` (512).
- R8: In single-block mode (`multi_blk` = 0) the receiver goes idle after one block. Later start bits produce no output until the next `rd_start`.
- R9: In multi-block mode, after each block the receiver waits for a new start bit with the timeout count restarted.
- R10: When `stop_issued` is sampled high at edge t, the DAT samples at edges t, t+1 and t+2 are still used. From edge t+3 the receiver is idle, and a partly received block is discarded without `block_done`.
- R11: Status outputs are single-cycle pulses. `crc_ok` and `crc_err` never occur together, occur only with `block_done`, and never occur with `rd_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; DAT is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_start | input | 1 | Pulse: end bit of a read command was just sent |
| multi_blk | input | 1 | 1 = multi-block stream, 0 = single block |
| stop_issued | input | 1 | Pulse: end bit of the stop command is on the line |
| blk_len | input | LEN_W | Block length in bytes; 0 selects DEF_BLK_LEN |
| timeout_lim | input | TO_W | Maximum idle-high samples while hunting |
| dat_in | input | 1 | Sampled DAT line |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| block_done | output | 1 | Pulse: a whole block was received |
| crc_ok | output | 1 | Pulse with block_done: check bits matched |
| crc_err | output | 1 | Pulse with block_done: check bits differed |
| framing_err | output | 1 | Pulse with block_done: closing bit was 0 |
| rd_timeout | output | 1 | Pulse: no start bit within the limit |

## Verification
The assertions assume three things about the inputs. The consumer accepts each byte before the next one completes. `timeout_lim` is nonzero and does not change while the receiver is hunting. `blk_len` stays constant during a transfer. The stimulus follows all three: it changes the length and limit only between transfers, while the receiver is idle, and it keeps `out_ready` low for at most six cycles. The stop pulse is issued only during a multi-block stream, so the two-cycle tail is measured from a known end bit.

// File: rtl/sd_rx_pkg.sv
// Shared definitions for the SD block read receiver.
// Assumes: serial CRC16 with polynomial 0x1021, MSB-first bit order.
package sd_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_HUNT,
        RX_DATA,
        RX_CRC,
        RX_END
    } rx_state_t;

    localparam logic [15:0] CRC_POLY = 16'h1021;

    // One serial CRC16 step for a single incoming bit.
    function automatic logic [15:0] crc_step(input logic [15:0] cur, input logic din);
        crc_step = {cur[14:0], 1'b0} ^ ((cur[15] ^ din) ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/sd_rx_crc16.sv
// Serial CRC16 accumulator over the data bits of one block.
// Assumes: clr and en are never high together; clr marks the start bit.
module sd_rx_crc16
    import sd_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc_out
);

    // Accumulate one data bit per enabled cycle, restart at each start bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_out <= 16'h0000;
        end else if (en) begin
            crc_out <= crc_step(crc_out, din);
        end
    end

endmodule

// File: rtl/sd_rx_bytepack.sv
// Collects data bits into bytes and holds each byte for the consumer.
// Assumes: the consumer takes each byte before the next one is complete.
module sd_rx_bytepack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              byte_end,
    input  logic              din,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid
);

    logic [BYTE_W-2:0] shreg;

    // Shift the serial data bits in, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[BYTE_W-3:0], din};
        end
    end

    // Load a finished byte into the output register and hold it until it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else if (byte_end) begin
            out_data  <= {shreg, din};
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assert_hold_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_end && out_valid && !out_ready));

endmodule

// File: rtl/sd_rx_ctrl.sv
// Frame sequencer: start-bit hunt with timeout, data and check-bit counting,
// closing-bit test, per-block status and the two-clock stop tail.
// Assumes: blk_len and timeout_lim are stable while not idle; timeout_lim > 0.
module sd_rx_ctrl
    import sd_rx_pkg::*;
#(
    parameter int LEN_W       = 12,
    parameter int TO_W        = 16,
    parameter int DEF_BLK_LEN = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_start,
    input  logic             multi_blk,
    input  logic             stop_issued,
    input  logic             dat_in,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [TO_W-1:0]  timeout_lim,
    input  logic [15:0]      crc_calc,
    output logic             crc_clr,
    output logic             data_en,
    output logic             byte_end,
    output logic             block_done,
    output logic             crc_ok,
    output logic             crc_err,
    output logic             framing_err,
    output logic             rd_timeout
);

    localparam int CNT_W = LEN_W + 3;

    rx_state_t        state, state_n;
    logic [CNT_W-1:0] bit_cnt, cnt_n;
    logic [TO_W-1:0]  to_cnt, to_n;
    logic [15:0]      rx_crc, rx_crc_n;
    logic [1:0]       stop_cnt;
    logic [CNT_W-1:0] len_bits;
    logic             done_n, ok_n, cerr_n, ferr_n, tmo_n;

    // Block length in bits, with zero selecting the default length.
    assign len_bits = {((blk_len == '0) ? LEN_W'(DEF_BLK_LEN) : blk_len), 3'b000};

    // Strobes for the CRC and byte datapaths.
    assign crc_clr  = (state == RX_HUNT) && !dat_in;
    assign data_en  = (state == RX_DATA);
    assign byte_end = (state == RX_DATA) && (bit_cnt[2:0] == 3'd7);

    // Next-state and status decisions for the current DAT sample.
    always_comb begin
        state_n  = state;
        cnt_n    = bit_cnt;
        to_n     = to_cnt;
        rx_crc_n = rx_crc;
        done_n   = 1'b0;
        ok_n     = 1'b0;
        cerr_n   = 1'b0;
        ferr_n   = 1'b0;
        tmo_n    = 1'b0;
        case (state)
            RX_IDLE: begin
                if (rd_start) begin
                    state_n = RX_HUNT;
                    to_n    = '0;
                end
            end
            RX_HUNT: begin
                if (!dat_in) begin
                    state_n = RX_DATA;
                    cnt_n   = '0;
                end else if (to_cnt == timeout_lim - TO_W'(1)) begin
                    tmo_n   = 1'b1;
                    state_n = RX_IDLE;
                end else begin
                    to_n = to_cnt + TO_W'(1);
                end
            end
            RX_DATA: begin
                if (bit_cnt == len_bits - CNT_W'(1)) begin
                    state_n = RX_CRC;
                    cnt_n   = '0;
                end else begin
                    cnt_n = bit_cnt + CNT_W'(1);
                end
            end
            RX_CRC: begin
                rx_crc_n = {rx_crc[14:0], dat_in};
                if (bit_cnt == CNT_W'(15)) begin
                    state_n = RX_END;
                end else begin
                    cnt_n = bit_cnt + CNT_W'(1);
                end
            end
            RX_END: begin
                done_n  = 1'b1;
                ok_n    = (rx_crc == crc_calc);
                cerr_n  = (rx_crc != crc_calc);
                ferr_n  = !dat_in;
                state_n = multi_blk ? RX_HUNT : RX_IDLE;
                to_n    = '0;
            end
            default: state_n = RX_IDLE;
        endcase
        if (stop_cnt == 2'd1) begin
            state_n = RX_IDLE;
        end
    end

    // State, counters and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= RX_IDLE;
            bit_cnt     <= '0;
            to_cnt      <= '0;
            rx_crc      <= '0;
            block_done  <= 1'b0;
            crc_ok      <= 1'b0;
            crc_err     <= 1'b0;
            framing_err <= 1'b0;
            rd_timeout  <= 1'b0;
        end else begin
            state       <= state_n;
            bit_cnt     <= cnt_n;
            to_cnt      <= to_n;
            rx_crc      <= rx_crc_n;
            block_done  <= done_n;
            crc_ok      <= ok_n;
            crc_err     <= cerr_n;
            framing_err <= ferr_n;
            rd_timeout  <= tmo_n;
        end
    end

    // Two-clock tail after the stop command's end bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_cnt <= 2'd0;
        end else if (stop_cnt != 2'd0) begin
            stop_cnt <= stop_cnt - 2'd1;
        end else if (stop_issued && (state != RX_IDLE)) begin
            stop_cnt <= 2'd2;
        end
    end

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cnt == 2'd1) |=> (state == RX_IDLE));

    assert_timeout_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_timeout |-> (state == RX_IDLE));

    assert_hunt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HUNT) |-> (to_cnt < timeout_lim));

endmodule

// File: rtl/sd_blk_rx.sv
// Top of the SD single-line block read receiver: sequencer, CRC and byte path.
// Assumes: dat_in is already synchronous to clk; inputs obey the notes in the brief.
module sd_blk_rx #(
    parameter int LEN_W       = 12,
    parameter int TO_W        = 16,
    parameter int DEF_BLK_LEN = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_start,
    input  logic             multi_blk,
    input  logic             stop_issued,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [TO_W-1:0]  timeout_lim,
    input  logic             dat_in,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             block_done,
    output logic             crc_ok,
    output logic             crc_err,
    output logic             framing_err,
    output logic             rd_timeout
);

    logic        crc_clr, data_en, byte_end;
    logic [15:0] crc_calc;

    sd_rx_ctrl #(
        .LEN_W      (LEN_W),
        .TO_W       (TO_W),
        .DEF_BLK_LEN(DEF_BLK_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_start   (rd_start),
        .multi_blk  (multi_blk),
        .stop_issued(stop_issued),
        .dat_in     (dat_in),
        .blk_len    (blk_len),
        .timeout_lim(timeout_lim),
        .crc_calc   (crc_calc),
        .crc_clr    (crc_clr),
        .data_en    (data_en),
        .byte_end   (byte_end),
        .block_done (block_done),
        .crc_ok     (crc_ok),
        .crc_err    (crc_err),
        .framing_err(framing_err),
        .rd_timeout (rd_timeout)
    );

    sd_rx_crc16 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (crc_clr),
        .en     (data_en),
        .din    (dat_in),
        .crc_out(crc_calc)
    );

    sd_rx_bytepack #(.BYTE_W(8)) u_bytes (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (data_en),
        .byte_end (byte_end),
        .din      (dat_in),
        .out_ready(out_ready),
        .out_data (out_data),
        .out_valid(out_valid)
    );

    assert_crc_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({crc_ok, crc_err}));

    assert_status_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ok || crc_err || framing_err) |-> block_done);

    assert_done_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |-> (crc_ok ^ crc_err));

    assert_done_not_timeout_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(block_done && rd_timeout));

endmodule

// File: tb/sim_sd_blk_rx.sv
// Bench: behavioural card stimulus plus a cycle-by-cycle reference model.
module sim_sd_blk_rx;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 12;
    localparam int TO_W       = 16;
    localparam int DEF_LEN    = 512;
    localparam int WD_LIMIT   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_start = 1'b0;
    logic             multi_blk = 1'b0;
    logic             stop_issued = 1'b0;
    logic             dat_in = 1'b1;
    logic             out_ready = 1'b1;
    logic [LEN_W-1:0] blk_len = 12'd4;
    logic [TO_W-1:0]  timeout_lim = 16'd40;
    logic [7:0]       out_data;
    logic             out_valid, block_done, crc_ok, crc_err, framing_err, rd_timeout;

    sd_blk_rx #(.LEN_W(LEN_W), .TO_W(TO_W), .DEF_BLK_LEN(DEF_LEN)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .multi_blk(multi_blk),
        .stop_issued(stop_issued), .blk_len(blk_len), .timeout_lim(timeout_lim),
        .dat_in(dat_in), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .block_done(block_done), .crc_ok(crc_ok), .crc_err(crc_err),
        .framing_err(framing_err), .rd_timeout(rd_timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vecs = 0;
    int errs = 0;
    int cyc  = 0;
    bit done_flag = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    int         ph, cnt, tmo, stopc;
    bit         mq[$];
    logic [15:0] mrc;
    logic [7:0] sh;
    logic       e_valid, e_done, e_ok, e_cerr, e_ferr, e_tmo;
    logic [7:0] e_data;
    bit         live = 1'b0;

    function automatic logic [15:0] model_crc();
        logic [15:0] c = 16'h0;
        foreach (mq[i]) begin
            logic fb = c[15] ^ mq[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    always @(posedge clk) begin
        int old_s, prev_ph, lenb;
        live = rst_n;
        if (!rst_n) begin
            ph = 0; cnt = 0; tmo = 0; stopc = 0; mq.delete(); mrc = 0; sh = 0;
            e_valid = 0; e_data = 0; e_done = 0; e_ok = 0; e_cerr = 0; e_ferr = 0; e_tmo = 0;
        end else begin
            e_done = 0; e_ok = 0; e_cerr = 0; e_ferr = 0; e_tmo = 0;
            if (e_valid && out_ready) e_valid = 0;
            old_s = stopc; prev_ph = ph;
            lenb = 8 * ((blk_len == 0) ? DEF_LEN : int'(blk_len));
            case (ph)
                0: if (rd_start) begin ph = 1; tmo = 0; end
                1: if (dat_in == 1'b0) begin ph = 2; cnt = 0; mq.delete(); end
                   else begin
                       tmo++;
                       if (tmo >= int'(timeout_lim)) begin e_tmo = 1; ph = 0; end
                   end
                2: begin
                       mq.push_back(dat_in); sh = {sh[6:0], dat_in}; cnt++;
                       if (cnt % 8 == 0) begin e_data = sh; e_valid = 1; end
                       if (cnt == lenb) begin ph = 3; cnt = 0; end
                   end
                3: begin mrc = {mrc[14:0], dat_in}; cnt++; if (cnt == 16) ph = 4; end
                default: begin
                       e_done = 1;
                       if (model_crc() == mrc) e_ok = 1; else e_cerr = 1;
                       e_ferr = (dat_in == 1'b0);
                       ph = multi_blk ? 1 : 0; tmo = 0;
                   end
            endcase
            if (old_s == 1) ph = 0;
            if (old_s != 0) stopc = old_s - 1;
            else if (stop_issued && prev_ph != 0) stopc = 2;
        end
    end

    // Compare every output against the model between edges.
    always @(negedge clk) begin
        if (live && !done_flag) begin
            chk(out_valid === e_valid, "R3 out_valid", out_valid, e_valid);
            if (e_valid) chk(out_data === e_data, "R2 out_data", out_data, e_data);
            chk(block_done === e_done, "R4 block_done", block_done, e_done);
            chk(crc_ok === e_ok, "R4 crc_ok", crc_ok, e_ok);
            chk(crc_err === e_cerr, "R4 crc_err", crc_err, e_cerr);
            chk(framing_err === e_ferr, "R5 framing_err", framing_err, e_ferr);
            chk(rd_timeout === e_tmo, "R6 rd_timeout", rd_timeout, e_tmo);
        end
    end

    // ---------------- independent event counters ----------------
    int n_bytes = 0, n_done = 0, n_ok = 0, n_cerr = 0, n_ferr = 0, n_tmo = 0;
    logic [7:0] rq[$];

    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (out_valid && out_ready) begin n_bytes++; rq.push_back(out_data); end
            if (block_done) n_done++;
            if (crc_ok) n_ok++;
            if (crc_err) n_cerr++;
            if (framing_err) n_ferr++;
            if (rd_timeout) n_tmo++;
        end
        if (cyc > WD_LIMIT && !done_flag) begin
            done_flag = 1'b1;
            errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    // ---------------- card stimulus ----------------
    bit fq[$];

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 13 + i * 37 + 5) & 255);
    endfunction

    function automatic void build_frame(input int nb, input int seed, input bit bad_crc, input bit bad_end);
        logic [15:0] c = 16'h0;
        fq.delete();
        fq.push_back(1'b0);
        for (int i = 0; i < nb; i++) begin
            logic [7:0] b = pat(seed, i);
            for (int k = 7; k >= 0; k--) begin
                logic fb = c[15] ^ b[k];
                fq.push_back(b[k]);
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        if (bad_crc) c = c ^ 16'h0004;
        for (int k = 15; k >= 0; k--) fq.push_back(c[k]);
        fq.push_back(!bad_end);
    endfunction

    task automatic play_one(input bit stop);
        @(negedge clk);
        rd_start = 1'b0;
        stop_issued = stop;
        dat_in = (fq.size() > 0) ? fq.pop_front() : 1'b1;
    endtask

    task automatic play(input int n);
        repeat (n) play_one(1'b0);
    endtask

    task automatic play_all();
        while (fq.size() > 0) play_one(1'b0);
    endtask

    task automatic gap(input int n);
        fq.delete();
        repeat (n) play_one(1'b0);
    endtask

    task automatic issue_read(input logic m);
        @(negedge clk);
        multi_blk = m; rd_start = 1'b1; stop_issued = 1'b0; dat_in = 1'b1;
    endtask

    task automatic check_bytes(input int from, input int nb, input int seed, input string tag);
        for (int i = 0; i < nb; i++) begin
            logic [7:0] got = (from + i < rq.size()) ? rq[from + i] : 8'hxx;
            chk(got === pat(seed, i), tag, got, pat(seed, i));
        end
    endtask

    initial begin
        int b0, d0, k0, c0, f0, t0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({out_valid, block_done, crc_ok, crc_err, framing_err, rd_timeout} == 6'b0, "R1 outputs after reset",
            {out_valid, block_done, crc_ok, crc_err, framing_err, rd_timeout}, 0);
        gap(5);
        chk(n_bytes == 0 && n_done == 0, "R1 no activity without read", n_bytes + n_done, 0);

        // R2 R4 R7: good single block of 4 bytes after an access gap
        b0 = n_bytes; d0 = n_done; k0 = n_ok;
        issue_read(1'b0); gap(6);
        build_frame(4, 10, 0, 0); play_all(); gap(4);
        chk(n_bytes - b0 == 4, "R7 byte count", n_bytes - b0, 4);
        chk(n_ok - k0 == 1 && n_done - d0 == 1, "R4 good block", n_ok - k0, 1);
        check_bytes(b0, 4, 10, "R2 byte value");

        // R8: frame without a new read is ignored
        b0 = n_bytes;
        build_frame(4, 11, 0, 0); play_all(); gap(4);
        chk(n_bytes == b0, "R8 ignored after single block", n_bytes - b0, 0);

        // R4: corrupted check bits
        c0 = n_cerr;
        issue_read(1'b0); gap(3);
        build_frame(4, 20, 1, 0); play_all(); gap(3);
        chk(n_cerr - c0 == 1, "R4 crc error", n_cerr - c0, 1);

        // R5: missing end bit
        f0 = n_ferr; k0 = n_ok;
        issue_read(1'b0); gap(2);
        build_frame(4, 30, 0, 1); play_all(); gap(3);
        chk(n_ferr - f0 == 1, "R5 framing error", n_ferr - f0, 1);
        chk(n_ok - k0 == 1, "R5 crc still good", n_ok - k0, 1);

        // R6: no start bit within the limit
        timeout_lim = 16'd20; t0 = n_tmo; b0 = n_bytes;
        issue_read(1'b0); gap(30);
        chk(n_tmo - t0 == 1, "R6 timeout", n_tmo - t0, 1);
        chk(n_bytes == b0, "R6 no bytes", n_bytes - b0, 0);

        // R3: back-pressure across the first byte
        timeout_lim = 16'd40; b0 = n_bytes;
        issue_read(1'b0); gap(3);
        build_frame(4, 40, 0, 0);
        play(6); out_ready = 1'b0; play(6); out_ready = 1'b1;
        play_all(); gap(3);
        chk(n_bytes - b0 == 4, "R3 bytes under back-pressure", n_bytes - b0, 4);
        check_bytes(b0, 4, 40, "R3 held byte value");

        // R9 R10: multi-block stream cut by stop
        blk_len = 12'd3; b0 = n_bytes; d0 = n_done; k0 = n_ok;
        issue_read(1'b1); gap(5);
        build_frame(3, 50, 0, 0); play_all(); gap(9);
        build_frame(3, 51, 0, 0); play_all(); gap(4);
        build_frame(3, 52, 0, 0); play(15); play_one(1'b1); play(2); play_all(); gap(5);
        chk(n_done - d0 == 2, "R10 partial block dropped", n_done - d0, 2);
        chk(n_ok - k0 == 2, "R9 back-to-back blocks", n_ok - k0, 2);
        chk(n_bytes - b0 == 8, "R10 bytes through stop tail", n_bytes - b0, 8);
        b0 = n_bytes;
        build_frame(3, 53, 0, 0); play_all(); gap(3);
        chk(n_bytes == b0, "R10 idle after stop", n_bytes - b0, 0);

        // R9: multi-block ends by timeout with restarted count
        timeout_lim = 16'd20; t0 = n_tmo; d0 = n_done;
        issue_read(1'b1); gap(15);
        build_frame(3, 60, 0, 0); play_all(); gap(15);
        build_frame(3, 61, 0, 0); play_all(); gap(25);
        chk(n_done - d0 == 2 && n_tmo - t0 == 1, "R9 timeout restarted per block", n_done - d0, 2);

        // R7: length zero selects the default length
        blk_len = 12'd0; timeout_lim = 16'd40; b0 = n_bytes; k0 = n_ok;
        issue_read(1'b0); gap(4);
        build_frame(DEF_LEN, 70, 0, 0); play_all(); gap(3);
        chk(n_bytes - b0 == DEF_LEN, "R7 default length", n_bytes - b0, DEF_LEN);
        chk(n_ok - k0 == 1, "R7 default block crc", n_ok - k0, 1);

        // R11: verdict accounting
        chk(n_ok + n_cerr == n_done, "R11 one verdict per block", n_ok + n_cerr, n_done);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule